// File: doc/BRIEF.md
# Host-Bound Stream Buffer Channel

This block is the device-to-host half of one streaming channel. A producer hands it fixed-width words through a valid/ready port. The block places each word into a ring of equally sized buffers in host memory, and it issues one write request per word, carrying the target address and the data. When a buffer is complete, the block passes that buffer to the host by posting a 32-bit notice on a message port and pulsing an interrupt request. The host therefore learns about new data without ever reading a status register from the device.

The host drives the block through single-word control writes. It can open or close the channel and pick synchronous operation when it opens. It can hand a consumed buffer back by index, and it can ask for the partly filled current buffer to be sent now. In synchronous operation it grants word credits, and it sets the memory base of the ring. The block also posts a separate notice when a fresh buffer receives its first word, so that the host can poll the channel. It checks the ring's placement against the 4 KB page rule.

Top module: `chnbuf_ctrl`

## Requirements
- R1: After reset the channel is closed: `usr_ready`, `dma_valid`, `msg_valid` and `irq_req` are all 0.
- R2: Each word accepted (`usr_valid && usr_ready`) appears on the DMA port on the next cycle. The address is ring base + buffer index × BUF_BYTES + fill position × word bytes, and the data is the accepted word.
- R3: When a buffer receives its last word, a release notice is queued. A notice is laid out as opcode [31:28], channel number [27:20], buffer index [19:12] and count in words [11:0]. A release notice carries opcode 1 and a count of 0 for a full buffer. The next buffer index wraps modulo BUF_NUM.
- R4: A buffer handed to the host is never written again until the host writes command 1 with the buffer index in `ctl_data`. While the current buffer is held by the host, `usr_ready` stays low.
- R5: Command 2 (flush) sends the current buffer with its partial word count once no word is being accepted. A flush on an empty buffer posts no notice.
- R6: With NONEMPTY_EN set, the first word written into an empty current buffer queues a notice with opcode 2, that buffer's index and a count of 0.
- R7: A notice on the message port stays valid and unchanged until `msg_ready`. When a non-empty notice and a release notice are both waiting, the non-empty notice is issued first.
- R8: `irq_req` is high for exactly the one cycle after a release notice is taken at the message port, and low otherwise.
- R9: Command 0 with `ctl_data[1]=1` opens the channel in synchronous mode. In that mode only as many words are accepted as granted by command 3 (`ctl_data[15:0]` words added).
- R10: Command 0 with `ctl_data[0]=0` closes the channel. Closing clears the fill position, frees every buffer, returns the index to 0, drops waiting notices and credits, and holds `usr_ready` low.
- R11: Command 4 loads the ring base. `base_err` is high when any buffer smaller than 4 KB crosses a 4 KB boundary, or when any buffer of 4 KB or more is not 4 KB aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_valid | input | 1 | Producer word valid |
| usr_data | input | WORD_BITS | Producer word |
| usr_ready | output | 1 | Block accepts the word this cycle |
| ctl_we | input | 1 | Host control write strobe |
| ctl_sel | input | 3 | Command: 0 open/close, 1 release, 2 flush, 3 credit, 4 ring base |
| ctl_data | input | 32 | Command argument |
| dma_valid | output | 1 | Write request valid |
| dma_addr | output | 32 | Host byte address of the word |
| dma_data | output | WORD_BITS | Word to write |
| msg_valid | output | 1 | Notice valid |
| msg_data | output | 32 | Notice word |
| msg_ready | input | 1 | Message consumer takes the notice |
| irq_req | output | 1 | Interrupt request pulse |
| base_err | output | 1 | Ring placement violates the page rule |

## Verification
The main path is driven with random word streams of random density, while the host hands buffers back at random and sometimes late. This lets a stalled ring and index wraparound show up as backpressure, kept apart from plain idle cycles. Directed sequences hold `msg_ready` low so that non-empty and release notices pile up, which separates the order given by priority from the order in which the events happened. Flushes on empty and partial buffers separate a zero count from a full-buffer count. A credit-limited synchronous run and base addresses placed just inside and just across a page edge complete the set.

// File: rtl/chnbuf_pkg.sv
package chnbuf_pkg;
   typedef enum logic [3:0] {
      OP_NONE     = 4'd0,
      OP_RELEASE  = 4'd1,
      OP_NONEMPTY = 4'd2
   } msg_op_e;

   localparam logic [2:0] CMD_OPEN    = 3'd0;
   localparam logic [2:0] CMD_RELEASE = 3'd1;
   localparam logic [2:0] CMD_FLUSH   = 3'd2;
   localparam logic [2:0] CMD_CREDIT  = 3'd3;
   localparam logic [2:0] CMD_BASE    = 3'd4;

   function automatic logic [31:0] make_msg(msg_op_e op, logic [7:0] ch,
                                            logic [7:0] idx, logic [11:0] cnt);
      return {op, ch, idx, cnt};
   endfunction
endpackage

// File: rtl/chnbuf_ring.sv
module chnbuf_ring #(
   parameter int BUF_NUM = 4,
   parameter int WPB     = 4,
   localparam int IDX_W  = $clog2(BUF_NUM),
   localparam int FILL_W = $clog2(WPB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              acc,
   input  logic              flush_req,
   input  logic              rel_free,
   input  logic              rel_we,
   input  logic [IDX_W-1:0]  rel_idx,
   output logic [IDX_W-1:0]  cur_idx,
   output logic [FILL_W-1:0] fill,
   output logic              cur_busy,
   output logic              submit,
   output logic [11:0]       sub_cnt
);
   localparam logic [FILL_W-1:0] LAST = FILL_W'(WPB - 1);

   logic [BUF_NUM-1:0] owned_q;
   logic [IDX_W-1:0]   cur_q;
   logic [FILL_W-1:0]  fill_q;
   logic               fpend_q;
   logic               full_acc, flush_go;

   assign full_acc = acc && (fill_q == LAST);
   assign flush_go = fpend_q && (fill_q != '0) && !acc && rel_free;
   assign submit   = full_acc || flush_go;
   assign sub_cnt  = full_acc ? 12'd0 : 12'(fill_q);
   assign cur_idx  = cur_q;
   assign fill     = fill_q;
   assign cur_busy = owned_q[cur_q];

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         owned_q <= '0;
         cur_q   <= '0;
         fill_q  <= '0;
         fpend_q <= 1'b0;
      end else begin
         if (acc)
            fill_q <= full_acc ? '0 : fill_q + 1'b1;
         else if (flush_go)
            fill_q <= '0;
         if (submit)
            cur_q <= cur_q + 1'b1;
         for (int i = 0; i < BUF_NUM; i++) begin
            if (rel_we && (rel_idx == IDX_W'(i)))
               owned_q[i] <= 1'b0;
            if (submit && (cur_q == IDX_W'(i)))
               owned_q[i] <= 1'b1;
         end
         if (flush_req)
            fpend_q <= 1'b1;
         else if (flush_go || fill_q == '0)
            fpend_q <= 1'b0;
      end
   end

   // R10
   close_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (fill_q == '0) && (owned_q == '0) && (cur_q == '0));
   // R4
   release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_we && !clr) |=> (owned_q[$past(rel_idx)] == 1'b0));
   // R4
   no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |-> !owned_q[cur_q]);
endmodule

// File: rtl/chnbuf_msgq.sv
module chnbuf_msgq
   import chnbuf_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        ne_set,
   input  logic [31:0] ne_word,
   input  logic        rel_set,
   input  logic [31:0] rel_word,
   output logic        rel_busy,
   input  logic        msg_ready,
   output logic        msg_valid,
   output logic [31:0] msg_data,
   output logic        irq_req
);
   logic        ne_pend, rel_pend, out_v, irq_q;
   logic [31:0] ne_q, rel_q, out_d;
   logic        load;

   assign load      = !out_v || msg_ready;
   assign rel_busy  = rel_pend;
   assign msg_valid = out_v;
   assign msg_data  = out_d;
   assign irq_req   = irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ne_pend  <= 1'b0;
         rel_pend <= 1'b0;
         out_v    <= 1'b0;
         out_d    <= '0;
         ne_q     <= '0;
         rel_q    <= '0;
         irq_q    <= 1'b0;
      end else begin
         irq_q <= out_v && msg_ready && (out_d[31:28] == OP_RELEASE);
         if (load) begin
            out_v <= ne_pend || rel_pend;
            if (ne_pend)
               out_d <= ne_q;
            else if (rel_pend)
               out_d <= rel_q;
         end
         if (clr)
            ne_pend <= 1'b0;
         else if (ne_set) begin
            ne_pend <= 1'b1;
            ne_q    <= ne_word;
         end else if (load)
            ne_pend <= 1'b0;
         if (clr)
            rel_pend <= 1'b0;
         else if (rel_set) begin
            rel_pend <= 1'b1;
            rel_q    <= rel_word;
         end else if (load && !ne_pend)
            rel_pend <= 1'b0;
      end
   end

   // R7
   msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_v && !msg_ready) |=> out_v && $stable(out_d));
   // R7
   ne_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && ne_pend && rel_pend) |=> (out_d[31:28] == OP_NONEMPTY) && rel_pend);
   // R8
   irq_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> $past(out_v && msg_ready));
endmodule

// File: rtl/chnbuf_geom.sv
module chnbuf_geom #(
   parameter int BUF_BYTES = 16,
   parameter int BUF_NUM   = 4
) (
   input  logic [31:0] ring_base,
   output logic        base_err
);
   localparam int PAGE = 4096;
   logic [BUF_NUM-1:0] bad;

   for (genvar i = 0; i < BUF_NUM; i++) begin : g_buf
      logic [31:0] b;
      assign b = ring_base + 32'(i) * 32'(BUF_BYTES);
      if (BUF_BYTES < PAGE) begin : g_small
         assign bad[i] = ((b ^ (b + 32'(BUF_BYTES - 1))) >> 12) != 32'd0;
      end else begin : g_big
         assign bad[i] = (b & 32'(PAGE - 1)) != 32'd0;
      end
   end

   assign base_err = |bad;
endmodule

// File: rtl/chnbuf_ctrl.sv
module chnbuf_ctrl
   import chnbuf_pkg::*;
#(
   parameter int WORD_BITS   = 32,
   parameter int BUF_BYTES   = 16,
   parameter int BUF_NUM     = 4,
   parameter int CHAN_ID     = 5,
   parameter bit NONEMPTY_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 usr_valid,
   input  logic [WORD_BITS-1:0] usr_data,
   output logic                 usr_ready,
   input  logic                 ctl_we,
   input  logic [2:0]           ctl_sel,
   input  logic [31:0]          ctl_data,
   output logic                 dma_valid,
   output logic [31:0]          dma_addr,
   output logic [WORD_BITS-1:0] dma_data,
   output logic                 msg_valid,
   output logic [31:0]          msg_data,
   input  logic                 msg_ready,
   output logic                 irq_req,
   output logic                 base_err
);
   localparam int WORD_BYTES = WORD_BITS / 8;
   localparam int WPB        = BUF_BYTES / WORD_BYTES;
   localparam int IDX_W      = $clog2(BUF_NUM);
   localparam int FILL_W     = $clog2(WPB);
   localparam int BUF_SHIFT  = $clog2(BUF_BYTES);
   localparam int W_SHIFT    = $clog2(WORD_BYTES);

   if (WORD_BITS != 8 && WORD_BITS != 16 && WORD_BITS != 32) begin : g_bad_word
      $error("WORD_BITS must be 8, 16 or 32");
   end
   if (BUF_NUM < 2 || BUF_NUM > 256 || (BUF_NUM & (BUF_NUM - 1)) != 0) begin : g_bad_num
      $error("BUF_NUM must be a power of two in 2..256");
   end
   if ((BUF_BYTES & (BUF_BYTES - 1)) != 0 || WPB < 2 || WPB > 4096) begin : g_bad_size
      $error("BUF_BYTES must be a power of two holding 2..4096 words");
   end
   if (CHAN_ID < 0 || CHAN_ID > 255) begin : g_bad_chan
      $error("CHAN_ID must fit in 8 bits");
   end

   logic              open_q, sync_q;
   logic [15:0]       credit_q;
   logic [31:0]       base_q;
   logic              cmd_open, cmd_close, cmd_rel, cmd_flush, cmd_credit;
   logic              acc, has_credit, ne_set, rel_busy, cur_busy, submit;
   logic [IDX_W-1:0]  cur_idx;
   logic [FILL_W-1:0] fill;
   logic [11:0]       sub_cnt;
   logic [31:0]       ne_word, rel_word, offset;

   assign cmd_open   = ctl_we && (ctl_sel == CMD_OPEN) && ctl_data[0];
   assign cmd_close  = ctl_we && (ctl_sel == CMD_OPEN) && !ctl_data[0];
   assign cmd_rel    = ctl_we && (ctl_sel == CMD_RELEASE);
   assign cmd_flush  = ctl_we && (ctl_sel == CMD_FLUSH) && open_q;
   assign cmd_credit = ctl_we && (ctl_sel == CMD_CREDIT);

   assign has_credit = !sync_q || (credit_q != 16'd0);
   assign usr_ready  = open_q && !cur_busy && has_credit &&
                       !(rel_busy && (fill == FILL_W'(WPB - 1)));
   assign acc        = usr_valid && usr_ready;
   assign offset     = (32'(cur_idx) << BUF_SHIFT) + (32'(fill) << W_SHIFT);

   if (NONEMPTY_EN) begin : g_ne_on
      assign ne_set = acc && (fill == '0);
   end else begin : g_ne_off
      assign ne_set = 1'b0;
   end
   assign ne_word  = make_msg(OP_NONEMPTY, 8'(CHAN_ID), 8'(cur_idx), 12'd0);
   assign rel_word = make_msg(OP_RELEASE, 8'(CHAN_ID), 8'(cur_idx), sub_cnt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q    <= 1'b0;
         sync_q    <= 1'b0;
         credit_q  <= '0;
         base_q    <= '0;
         dma_valid <= 1'b0;
         dma_addr  <= '0;
         dma_data  <= '0;
      end else begin
         dma_valid <= acc;
         if (acc) begin
            dma_addr <= base_q + offset;
            dma_data <= usr_data;
         end
         if (cmd_open) begin
            open_q <= 1'b1;
            sync_q <= ctl_data[1];
         end else if (cmd_close) begin
            open_q <= 1'b0;
            sync_q <= 1'b0;
         end
         if (cmd_close)
            credit_q <= '0;
         else
            credit_q <= credit_q + (cmd_credit ? ctl_data[15:0] : 16'd0)
                        - {15'd0, acc && sync_q};
         if (ctl_we && ctl_sel == CMD_BASE)
            base_q <= ctl_data;
      end
   end

   chnbuf_ring #(.BUF_NUM(BUF_NUM), .WPB(WPB)) u_ring (
      .clk(clk), .rst_n(rst_n), .clr(cmd_close), .acc(acc),
      .flush_req(cmd_flush), .rel_free(!rel_busy), .rel_we(cmd_rel),
      .rel_idx(ctl_data[IDX_W-1:0]), .cur_idx(cur_idx), .fill(fill),
      .cur_busy(cur_busy), .submit(submit), .sub_cnt(sub_cnt));

   chnbuf_msgq u_msgq (
      .clk(clk), .rst_n(rst_n), .clr(cmd_close), .ne_set(ne_set),
      .ne_word(ne_word), .rel_set(submit), .rel_word(rel_word),
      .rel_busy(rel_busy), .msg_ready(msg_ready), .msg_valid(msg_valid),
      .msg_data(msg_data), .irq_req(irq_req));

   chnbuf_geom #(.BUF_BYTES(BUF_BYTES), .BUF_NUM(BUF_NUM)) u_geom (
      .ring_base(base_q), .base_err(base_err));

   // R2
   dma_from_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_valid |-> $past(open_q));
   // R9
   credit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_q && $past(sync_q) && $past(credit_q) == 16'd0 && !$past(cmd_credit)) |-> !dma_valid);
endmodule

// File: tb/tb_chnbuf_ctrl.sv
`timescale 1ns/1ps
module tb_chnbuf_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        usr_valid = 1'b0;
   logic [31:0] usr_data = '0;
   logic        usr_ready;
   logic        ctl_we = 1'b0;
   logic [2:0]  ctl_sel = '0;
   logic [31:0] ctl_data = '0;
   logic        dma_valid;
   logic [31:0] dma_addr;
   logic [31:0] dma_data;
   logic        msg_valid;
   logic [31:0] msg_data;
   logic        msg_ready = 1'b1;
   logic        irq_req;
   logic        base_err;

   always #4 clk = ~clk;

   chnbuf_ctrl #(.WORD_BITS(32), .BUF_BYTES(16), .BUF_NUM(4), .CHAN_ID(5),
                 .NONEMPTY_EN(1'b1)) dut (.*);

   int vecs = 0, miss = 0;
   bit done = 1'b0;
   bit m_open = 0, m_sync = 0;
   int m_cur = 0, m_fill = 0, m_credit = 0;
   bit m_owned [4];
   logic [31:0] m_base = '0;
   logic [31:0] rel_q[$], ne_q[$];
   int ord[$];
   bit   exp_dv = 0, irq_exp = 0;
   logic [31:0] exp_da = '0, exp_dd = '0;

   function automatic logic [31:0] mk(int op, int idx, int cnt);
      return {4'(op), 8'd5, 8'(idx), 12'(cnt)};
   endfunction

   function automatic bit exp_berr(logic [31:0] b);
      bit e = 0;
      for (int i = 0; i < 4; i++) begin
         logic [31:0] s = b + 32'(i * 16);
         logic [31:0] t = s + 32'd15;
         if (s[31:12] != t[31:12]) e = 1;
      end
      return e;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         miss++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_submit(int cnt);
      rel_q.push_back(mk(1, m_cur, cnt));
      m_owned[m_cur] = 1;
      m_cur = (m_cur + 1) % 4;
      m_fill = 0;
   endtask

   task automatic step(bit v, logic [31:0] d, bit we, logic [2:0] sel,
                       logic [31:0] cd, bit mr);
      bit rdy;
      @(negedge clk);
      chk("R2 dma_valid", 32'(dma_valid), 32'(exp_dv));
      if (exp_dv) begin
         chk("R2 dma_addr", dma_addr, exp_da);
         chk("R2 dma_data", dma_data, exp_dd);
      end
      chk("R8 irq_req", 32'(irq_req), 32'(irq_exp));
      chk("R11 base_err", 32'(base_err), 32'(exp_berr(m_base)));
      usr_valid = v; usr_data = d; ctl_we = we; ctl_sel = sel;
      ctl_data = cd; msg_ready = mr;
      #1;
      rdy = m_open && !m_owned[m_cur] && (!m_sync || m_credit > 0);
      chk("R4/R9/R10 usr_ready", 32'(usr_ready), 32'(rdy));
      irq_exp = 0;
      if (msg_valid && mr) begin
         ord.push_back(int'(msg_data[31:28]));
         if (msg_data[31:28] == 4'd1) begin
            irq_exp = 1;
            if (rel_q.size() == 0) chk("R3 unexpected release", msg_data, 32'h0);
            else chk("R3/R5 release notice", msg_data, rel_q.pop_front());
         end else begin
            if (ne_q.size() == 0) chk("R6 unexpected notice", msg_data, 32'h0);
            else chk("R6 non-empty notice", msg_data, ne_q.pop_front());
         end
      end
      exp_dv = 0;
      if (v && usr_ready) begin
         exp_dv = 1;
         exp_da = m_base + 32'(m_cur * 16 + m_fill * 4);
         exp_dd = d;
         if (m_fill == 0) ne_q.push_back(mk(2, m_cur, 0));
         m_fill++;
         if (m_sync) m_credit--;
         if (m_fill == 4) model_submit(0);
      end
      if (we) begin
         case (sel)
            3'd0: if (cd[0]) begin m_open = 1; m_sync = cd[1]; end
                  else begin
                     m_open = 0; m_sync = 0; m_credit = 0; m_cur = 0; m_fill = 0;
                     foreach (m_owned[i]) m_owned[i] = 0;
                  end
            3'd1: m_owned[cd[1:0]] = 0;
            3'd3: m_credit += int'(cd[15:0]);
            3'd4: m_base = cd;
            default: ;
         endcase
      end
   endtask

   task automatic idle(int n, bit mr);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, mr);
   endtask

   task automatic cmd(logic [2:0] sel, logic [31:0] cd);
      step(0, 0, 1, sel, cd, 1);
   endtask

   task automatic do_flush();
      cmd(3'd2, 0);
      step(0, 0, 0, 0, 0, 1);
      if (m_fill > 0) model_submit(m_fill);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         vecs++; miss++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      foreach (m_owned[i]) m_owned[i] = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 usr_ready", 32'(usr_ready), 0);
      chk("R1 msg_valid", 32'(msg_valid), 0);
      chk("R1 dma_valid", 32'(dma_valid), 0);
      chk("R1 irq_req", 32'(irq_req), 0);
      rst_n = 1'b1;

      // R11 placement corners
      cmd(3'd4, 32'h0000_0FF0); idle(1, 1);
      cmd(3'd4, 32'h0000_0FF8); idle(1, 1);
      cmd(3'd4, 32'h0000_0FE8); idle(1, 1);
      cmd(3'd4, 32'h0000_1FF0); idle(1, 1);
      cmd(3'd4, 32'h0000_2000); idle(1, 1);

      // R7 priority and hold: ready low while notices pile up
      cmd(3'd0, 32'h1);
      for (int i = 0; i < 5; i++) step(1, 32'hA000 + i, 0, 0, 0, 0);
      idle(3, 0);
      chk("R7 hold valid", 32'(msg_valid), 1);
      chk("R7 hold data", msg_data, mk(2, 0, 0));
      ord.delete();
      idle(6, 1);
      chk("R7 order count", 32'(ord.size()), 3);
      if (ord.size() == 3) begin
         chk("R7 first notice", 32'(ord[0]), 2);
         chk("R7 second notice non-empty first", 32'(ord[1]), 2);
         chk("R7 third notice", 32'(ord[2]), 1);
      end
      cmd(3'd1, 0);

      // R5 flush partial (buffer 1 holds one word), then flush on empty
      do_flush();
      idle(4, 1);
      do_flush();
      idle(4, 1);
      chk("R5 empty flush queue", 32'(rel_q.size()), 0);
      chk("R5 empty flush no notice", 32'(msg_valid), 0);

      // R10 close and reopen
      cmd(3'd0, 32'h0);
      idle(2, 1);
      step(1, 32'h55, 0, 0, 0, 1);
      cmd(3'd4, 32'h0000_4000);
      cmd(3'd0, 32'h1);

      // R3 R4 R6 random stream with random buffer returns
      for (int n = 0; n < 1500; n++) begin
         bit v = ($urandom % 4) != 0;
         int r = int'($urandom % 8);
         if (n % 97 == 96) begin
            do_flush();
         end else if (r < (n < 700 ? 3 : 1)) begin
            int idx = int'($urandom % 4);
            step(v, $urandom, m_owned[idx], 3'd1, 32'(idx), 1);
         end else begin
            step(v, $urandom, 0, 0, 0, 1);
         end
      end
      for (int i = 0; i < 4; i++) cmd(3'd1, 32'(i));
      idle(6, 1);
      chk("R3 release queue drained", 32'(rel_q.size()), 0);
      chk("R6 notice queue drained", 32'(ne_q.size()), 0);

      // R9 synchronous mode with credits
      cmd(3'd0, 32'h0);
      cmd(3'd0, 32'h3);
      step(1, 32'h1, 0, 0, 0, 1);
      cmd(3'd3, 32'd3);
      for (int i = 0; i < 6; i++) step(1, 32'hB0 + i, 0, 0, 0, 1);
      do_flush();
      idle(6, 1);
      chk("R9 sync notices drained", 32'(rel_q.size() + ne_q.size()), 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end
endmodule